// File: doc/BRIEF.md
# Four-Channel Programmable Down-Counter/Timer

This block holds four independent down-counting channels behind one 8-bit write port. A 2-bit select picks the channel, and each channel takes a control byte followed by a time-constant byte. In timer mode a channel divides the system clock by a prescaler of 16 or 256 and then by its time constant. In counter mode it counts the active edges of its own trigger input, which is first synchronised to the clock. When a channel's count runs out, it reloads the constant by itself, pulses a zero-count strobe, and may raise an interrupt request.

Channels 0 to 2 drive their zero-count strobes out to pins. Channel 3 has no output pin and is seen only through its interrupt. A strobe can be wired to the trigger of another channel to divide further. The interrupt side holds one pending flag per channel. It always presents the lowest-numbered pending channel, using a vector whose upper five bits come from a base written through channel 0 and whose bits 2 to 1 carry the channel number. An acknowledge strobe clears the presented flag.

Top module: `quad_down_timer`

## Requirements
- R1: After reset no channel counts, `zc_out` is 0, `irq_req` is 0 and `irq_vec` is 00h.
- R2: Control bit 0 = 1 marks a control byte. If bit 6 = 0 the channel is a timer, and if bit 5 = 0 its prescaler is 16. When bit 3 = 0 the timer starts at the edge that loads the constant T. Its strobe is high for one cycle at exactly 16·T clocks after that edge.
- R3: Control bit 5 = 1 sets a prescaler of 256, which gives a timer period of 256·T clocks.
- R4: A time constant of 00h counts as 256.
- R5: Control bit 6 = 1 sets counter mode. Bit 4 = 1 counts rising trigger edges and bit 4 = 0 counts falling edges. Each edge of the selected kind decrements the count once. The strobe appears 3 clocks after the trigger change that completes the count.
- R6: In timer mode with bit 3 = 1, loading the constant arms the channel without starting it. The timer then starts 3 clocks after the next active trigger change.
- R7: After a control byte with bit 2 = 1, the next byte to that channel is the time constant, even when its bit 0 is 1.
- R8: Control bit 1 = 1 stops the channel. Later control bytes do not restart it. Only a new time constant does.
- R9: A byte with bit 0 = 0 written to channel 0 while no constant is pending sets the vector base from bits 7 to 3. The same kind of byte sent to any other channel, or sent as a pending constant, leaves the base unchanged.
- R10: When control bit 7 = 1, a zero count sets that channel's pending flag 1 clock after the strobe. With bit 7 = 0 no interrupt is raised. While any flag is pending, `irq_vec` = base | (channel << 1).
- R11: Among pending channels the lowest-numbered one is presented. A cycle of `irq_ack` clears only that channel's flag.
- R12: A channel in counter mode whose trigger is fed by another channel's strobe divides that strobe rate by its own constant.
- R13: When the count runs out, the channel reloads the last constant without a new write, so the strobes repeat at a fixed period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_sel | input | 2 | Channel addressed by the write |
| wr_data | input | 8 | Control byte, time constant or vector base |
| trg_in | input | 4 | Per-channel clock/trigger inputs (asynchronous) |
| irq_ack | input | 1 | Acknowledge of the presented interrupt |
| zc_out | output | 3 | Zero-count strobes of channels 0 to 2 |
| irq_req | output | 1 | High while any channel is pending |
| irq_vec | output | 8 | Vector of the presented channel |

## Verification
The bench predicts the exact cycle of every strobe from the write or trigger edge. A wrong prescaler choice, or an off-by-one in the reload, shows up as a pulse early, late or missing. A time constant of zero is driven through 256 edges, so a design that treats it as zero or 255 fires at the wrong edge. A constant byte with bit 0 set, and a zero-bit-0 byte sent as a pending constant or to a channel other than 0, would be misread as a control word or a vector in a careless decoder. That would change the timing or the vector. Two simultaneous interrupts followed by acknowledges expose wrong priority or an acknowledge that clears both flags.

// File: rtl/qdt_pkg.sv
package qdt_pkg;

   // control byte bit positions (decoded by every channel)
   localparam int unsigned QDT_B_CTRL  = 0;
   localparam int unsigned QDT_B_STOP  = 1;
   localparam int unsigned QDT_B_TCNXT = 2;
   localparam int unsigned QDT_B_TSTRT = 3;
   localparam int unsigned QDT_B_EDGE  = 4;
   localparam int unsigned QDT_B_PSEL  = 5;
   localparam int unsigned QDT_B_MODE  = 6;
   localparam int unsigned QDT_B_IE    = 7;

   typedef struct packed {
      logic irq_en;
      logic cnt_mode;
      logic ps_big;
      logic rise_edge;
      logic trig_start;
   } qdt_cfg_t;

   function automatic qdt_cfg_t qdt_decode(input logic [7:0] b);
      qdt_cfg_t c;
      c.irq_en     = b[QDT_B_IE];
      c.cnt_mode   = b[QDT_B_MODE];
      c.ps_big     = b[QDT_B_PSEL];
      c.rise_edge  = b[QDT_B_EDGE];
      c.trig_start = b[QDT_B_TSTRT];
      return c;
   endfunction

endpackage

// File: rtl/qdt_trig_sync.sv
module qdt_trig_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trg_i,
   input  logic rise_i,
   output logic edge_o
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qdt_trig_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], trg_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign edge_o = rise_i ? (sync_q[STAGES-1] & ~prev_q)
                          : (~sync_q[STAGES-1] & prev_q);

endmodule

// File: rtl/qdt_channel.sv
module qdt_channel
   import qdt_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned PS_LO       = 16,
   parameter int unsigned PS_HI       = 256,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [DW-1:0] data_i,
   input  logic          trg_i,
   output logic          tc_pend_o,
   output logic          ie_o,
   output logic          zc_o
);
   localparam int unsigned CW  = DW + 1;
   localparam int unsigned PSW = $clog2(PS_HI);

   qdt_cfg_t          cfg_q;
   logic              tc_pend_q;
   logic [DW-1:0]     tc_q;
   logic [CW-1:0]     cnt_q;
   logic [PSW-1:0]    ps_q;
   logic              run_q, arm_q, zc_q;
   logic              trg_edge;
   logic [PSW-1:0]    ps_last;
   logic              ps_wrap, load_tc, soft_stop, dec;
   logic [CW-1:0]     reload;

   function automatic logic [CW-1:0] tc_eff(input logic [DW-1:0] v);
      return (v == '0) ? {1'b1, {DW{1'b0}}} : {1'b0, v};
   endfunction

   qdt_trig_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .trg_i  (trg_i),
      .rise_i (cfg_q.rise_edge),
      .edge_o (trg_edge)
   );

   always_comb begin
      ps_last   = cfg_q.ps_big ? PSW'(PS_HI - 1) : PSW'(PS_LO - 1);
      ps_wrap   = (ps_q == ps_last);
      load_tc   = wr_i & tc_pend_q;
      soft_stop = wr_i & ~tc_pend_q & data_i[QDT_B_CTRL] & data_i[QDT_B_STOP];
      dec       = run_q & ~load_tc & ~soft_stop &
                  (cfg_q.cnt_mode ? trg_edge : ps_wrap);
      reload    = tc_eff(tc_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         tc_pend_q <= 1'b0;
         tc_q      <= '0;
         cnt_q     <= '0;
         ps_q      <= '0;
         run_q     <= 1'b0;
         arm_q     <= 1'b0;
         zc_q      <= 1'b0;
      end else begin
         zc_q <= dec && (cnt_q == CW'(1));
         if (wr_i && !tc_pend_q && data_i[QDT_B_CTRL]) begin
            cfg_q     <= qdt_decode(data_i[7:0]);
            tc_pend_q <= data_i[QDT_B_TCNXT];
         end
         if (load_tc) begin
            tc_q      <= data_i;
            cnt_q     <= tc_eff(data_i);
            tc_pend_q <= 1'b0;
            ps_q      <= '0;
            if (!cfg_q.cnt_mode && cfg_q.trig_start) begin
               arm_q <= 1'b1;
               run_q <= 1'b0;
            end else begin
               arm_q <= 1'b0;
               run_q <= 1'b1;
            end
         end else if (soft_stop) begin
            run_q <= 1'b0;
            arm_q <= 1'b0;
            ps_q  <= '0;
         end else begin
            if (arm_q && trg_edge) begin
               run_q <= 1'b1;
               arm_q <= 1'b0;
               ps_q  <= '0;
            end else if (run_q && !cfg_q.cnt_mode) begin
               ps_q <= ps_wrap ? '0 : ps_q + PSW'(1);
            end
            if (dec) begin
               cnt_q <= (cnt_q == CW'(1)) ? reload : cnt_q - CW'(1);
            end
         end
      end
   end

   assign tc_pend_o = tc_pend_q;
   assign ie_o      = cfg_q.irq_en;
   assign zc_o      = zc_q;

   // R8: a stopped channel produces no strobe in the next cycle
   a_r8_stopped_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> !zc_q);
   // R4: a running channel never holds a zero count
   a_r4_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q != '0));
   // R13: the last decrement reloads the stored constant
   a_r13_auto_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && cnt_q == CW'(1)) |=> (cnt_q == $past(reload)));
   // R6: an armed timer stays idle until its trigger edge
   a_r6_wait_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q && !trg_edge && !wr_i) |=> !run_q);

endmodule

// File: rtl/qdt_irq.sv
module qdt_irq #(
   parameter int unsigned N_CH = 4,
   parameter int unsigned DW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] zc_i,
   input  logic [N_CH-1:0] ie_i,
   input  logic            ack_i,
   input  logic            vec_wr_i,
   input  logic [DW-1:0]   vec_data_i,
   output logic            req_o,
   output logic [DW-1:0]   vec_o
);
   localparam int unsigned IDX_W = 2;
   localparam int unsigned BW    = DW - IDX_W - 1;

   logic [N_CH-1:0]  pend_q, set_v, sel_oh;
   logic [IDX_W-1:0] sel_idx;
   logic [BW-1:0]    base_q;

   always_comb begin
      sel_idx = '0;
      sel_oh  = '0;
      for (int i = N_CH - 1; i >= 0; i--) begin
         if (pend_q[i]) begin
            sel_idx = IDX_W'(i);
            sel_oh  = N_CH'(1) << i;
         end
      end
      set_v = zc_i & ie_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         base_q <= '0;
      end else begin
         pend_q <= (pend_q & ~(ack_i ? sel_oh : '0)) | set_v;
         if (vec_wr_i) base_q <= vec_data_i[DW-1:IDX_W+1];
      end
   end

   assign req_o = |pend_q;
   assign vec_o = {base_q, sel_idx, 1'b0};

   // R10: a request appears only after an enabled zero count
   a_r10_req_from_event: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> $past(|(zc_i & ie_i)));
   // R11: acknowledging the only pending channel drops the request
   a_r11_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && $countones(pend_q) == 1 && !(|set_v)) |=> !req_o);
   // R11: at most one channel presented
   a_r11_one_presented: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_oh));
   // R9: the base moves only on a vector write
   a_r9_base_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_wr_i |=> $stable(base_q));

endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer #(
   parameter int unsigned N_CH        = 4,
   parameter int unsigned DW          = 8,
   parameter int unsigned PS_LO       = 16,
   parameter int unsigned PS_HI       = 256,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SEL_W      = $clog2(N_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [DW-1:0]    wr_data,
   input  logic [N_CH-1:0]  trg_in,
   input  logic             irq_ack,
   output logic [N_CH-2:0]  zc_out,
   output logic             irq_req,
   output logic [DW-1:0]    irq_vec
);
   logic [N_CH-1:0] tc_pend, ie, zc;
   logic            vec_wr;

   generate
      if (N_CH < 2 || N_CH > 4) begin : g_bad_nch
         $error("quad_down_timer: N_CH must be 2 to 4");
      end
      if (DW < 8) begin : g_bad_dw
         $error("quad_down_timer: DW must be at least 8");
      end
      if ((PS_LO & (PS_LO - 1)) != 0 || (PS_HI & (PS_HI - 1)) != 0) begin : g_bad_ps
         $error("quad_down_timer: prescalers must be powers of two");
      end
      if (PS_HI <= PS_LO || PS_LO < 2) begin : g_bad_order
         $error("quad_down_timer: PS_HI must exceed PS_LO >= 2");
      end

      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         qdt_channel #(
            .DW          (DW),
            .PS_LO       (PS_LO),
            .PS_HI       (PS_HI),
            .SYNC_STAGES (SYNC_STAGES)
         ) ch_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (wr_en && (wr_sel == SEL_W'(c))),
            .data_i    (wr_data),
            .trg_i     (trg_in[c]),
            .tc_pend_o (tc_pend[c]),
            .ie_o      (ie[c]),
            .zc_o      (zc[c])
         );
         if (c < N_CH - 1) begin : g_pin
            assign zc_out[c] = zc[c];
         end
      end
   endgenerate

   assign vec_wr = wr_en && (wr_sel == '0) && !wr_data[0] && !tc_pend[0];

   qdt_irq #(.N_CH(N_CH), .DW(DW)) irq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .zc_i       (zc),
      .ie_i       (ie),
      .ack_i      (irq_ack),
      .vec_wr_i   (vec_wr),
      .vec_data_i (wr_data),
      .req_o      (irq_req),
      .vec_o      (irq_vec)
   );

   // R1: no strobe or request while reset is applied
   a_r1_quiet_in_reset: assert property (@(posedge clk)
      !rst_n |=> (zc_out == '0 && !irq_req));

endmodule

// File: tb/quad_down_timer_tb_top.sv
module quad_down_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] trg_drv = '0;
   logic [3:0] trg_in;
   logic       cascade = 1'b0;
   logic       irq_ack = 1'b0;
   logic [2:0] zc_out;
   logic       irq_req;
   logic [7:0] irq_vec;

   typedef struct {
      int    ch;
      int    at;
      string req;
   } ev_t;

   ev_t exp_q[$];
   ev_t ev;
   int  cyc = 0;
   int  vectors = 0;
   int  miscompares = 0;
   int  last_w = 0;
   int  last_t = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign trg_in = {trg_drv[3:2], cascade ? zc_out[0] : trg_drv[1], trg_drv[0]};

   quad_down_timer dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .trg_in  (trg_in),
      .irq_ack (irq_ack),
      .zc_out  (zc_out),
      .irq_req (irq_req),
      .irq_vec (irq_vec)
   );

   // monitor: every strobe must match the next expected item
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int i = 0; i < 3; i++) begin
            if (zc_out[i]) begin
               vectors++;
               if (exp_q.size() == 0) begin
                  miscompares++;
                  $display("FAIL unexpected strobe: got ch%0d at %0d, expected none", i, cyc);
               end else begin
                  ev = exp_q.pop_front();
                  if (ev.ch != i || ev.at != cyc) begin
                     miscompares++;
                     $display("FAIL %s: got ch%0d at %0d, expected ch%0d at %0d",
                              ev.req, i, cyc, ev.ch, ev.at);
                  end
               end
            end
         end
      end
   end

   task automatic push(input int ch, input int at, input string req);
      ev_t e;
      e.ch = ch; e.at = at; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic chk(input string req, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         miscompares++;
         $display("FAIL %s: got %0h, expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(input int sel, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = d[7:0];
      @(negedge clk);
      wr_en = 1'b0;
      last_w = cyc;
   endtask

   task automatic set_trg(input int ch, input bit v);
      @(negedge clk);
      trg_drv[ch] = v;
      last_t = cyc;
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      while (exp_q.size() != 0) begin
         ev = exp_q.pop_front();
         vectors++;
         miscompares++;
         $display("FAIL %s: got no strobe, expected ch%0d at %0d", ev.req, ev.ch, ev.at);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      wait (cyc >= 100000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: got timeout at %0d, expected completion", cyc);
         finish_run();
      end
   end

   initial begin
      int w;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1 zc", int'(zc_out), 0);
      chk("R1 req", int'(irq_req), 0);
      chk("R1 vec", int'(irq_vec), 0);
      rst_n = 1'b1;
      repeat (50) @(negedge clk);

      // R2 / R13: ch0 timer, prescaler 16, T=5
      wr(0, 8'h07); wr(0, 8'h05); w = last_w;
      push(0, w + 80, "R2"); push(0, w + 160, "R13"); push(0, w + 240, "R13");
      wait_until(w + 250);
      // R8: stop, control byte without constant keeps it stopped
      wr(0, 8'h03);
      wait_until(w + 400);
      wr(0, 8'h01);
      wait_until(w + 600);
      chk("R10 no irq with ie=0", int'(irq_req), 0);
      wr(0, 8'h05); wr(0, 8'h01); w = last_w;
      push(0, w + 16, "R8");
      wait_until(w + 20);
      wr(0, 8'h03);

      // R3: ch2 prescaler 256, T=2
      wr(2, 8'h27); wr(2, 8'h02); w = last_w;
      push(2, w + 512, "R3"); push(2, w + 1024, "R3");
      wait_until(w + 1030);
      wr(2, 8'h23);

      // R7: constant byte with bit0=1
      wr(1, 8'h07); wr(1, 8'h03); w = last_w;
      push(1, w + 48, "R7"); push(1, w + 96, "R7");
      wait_until(w + 100);
      wr(1, 8'h03);

      // R5 / R13: counter mode, rising edges, T=3
      wr(1, 8'h57); wr(1, 8'h03);
      for (int k = 1; k <= 6; k++) begin
         set_trg(1, 1'b1);
         if (k == 3 || k == 6) push(1, last_t + 3, (k == 3) ? "R5" : "R13");
         repeat (3) @(negedge clk);
         set_trg(1, 1'b0);
         repeat (3) @(negedge clk);
      end
      // R5: falling edges, T=2
      wr(1, 8'h47); wr(1, 8'h02);
      for (int k = 1; k <= 2; k++) begin
         set_trg(1, 1'b1);
         repeat (3) @(negedge clk);
         set_trg(1, 1'b0);
         if (k == 2) push(1, last_t + 3, "R5");
         repeat (3) @(negedge clk);
      end

      // R4: constant 0 counts 256 edges
      wr(1, 8'h57); wr(1, 8'h00);
      for (int k = 1; k <= 256; k++) begin
         set_trg(1, 1'b1);
         if (k == 256) push(1, last_t + 3, "R4");
         set_trg(1, 1'b0);
      end
      repeat (10) @(negedge clk);
      wr(1, 8'h03);

      // R6: trigger-started timer on ch2
      wr(2, 8'h1F); wr(2, 8'h02); w = last_w;
      wait_until(w + 100);
      set_trg(2, 1'b1);
      push(2, last_t + 35, "R6"); push(2, last_t + 67, "R6");
      wait_until(last_t + 70);
      wr(2, 8'h23);
      set_trg(2, 1'b0);

      // R9: vector base, ignored writes
      wr(0, 8'h10);
      wr(1, 8'h20);
      wr(0, 8'h0F); wr(0, 8'h08);
      // R10: ch3 interrupt
      wr(3, 8'hD7); wr(3, 8'h01);
      set_trg(3, 1'b1);
      repeat (3) @(negedge clk);
      chk("R10 req not yet", int'(irq_req), 0);
      @(negedge clk);
      chk("R10 req", int'(irq_req), 1);
      chk("R9 vec ch3", int'(irq_vec), 8'h16);
      ack();
      chk("R11 ack clears", int'(irq_req), 0);
      set_trg(3, 1'b0);
      wr(0, 8'h03);

      // R11: priority between ch1 and ch3
      wr(1, 8'hD7); wr(1, 8'h01);
      repeat (4) @(negedge clk);
      @(negedge clk);
      trg_drv[1] = 1'b1; trg_drv[3] = 1'b1; last_t = cyc;
      push(1, last_t + 3, "R11");
      repeat (4) @(negedge clk);
      chk("R11 req", int'(irq_req), 1);
      chk("R11 lowest first", int'(irq_vec), 8'h12);
      ack();
      chk("R11 other left", int'(irq_req), 1);
      chk("R11 next vec", int'(irq_vec), 8'h16);
      ack();
      chk("R11 all clear", int'(irq_req), 0);
      set_trg(1, 1'b0); set_trg(3, 1'b0);
      repeat (5) @(negedge clk);
      wr(1, 8'h03); wr(3, 8'h03);

      // R12: ch0 strobes feed ch1 counter, T=3
      cascade = 1'b1;
      wr(1, 8'h57); wr(1, 8'h03);
      wr(0, 8'h07); wr(0, 8'h02); w = last_w;
      push(0, w + 32, "R12"); push(0, w + 64, "R12"); push(0, w + 96, "R12");
      push(1, w + 99, "R12");
      push(0, w + 128, "R12"); push(0, w + 160, "R12"); push(0, w + 192, "R12");
      push(1, w + 195, "R12");
      wait_until(w + 200);
      wr(0, 8'h03); wr(1, 8'h03);
      repeat (300) @(negedge clk);
      chk("R10 final req", int'(irq_req), 0);
      finish_run();
   end

endmodule